// File: doc/BRIEF.md
# Chip-Enable Gate with Backup-Battery Check

This block sits between a processor's active-low memory chip-enable and the memory itself. While the supervisor holds the system in reset, the chip-enable is blocked (driven high) so that a collapsing or restarting processor cannot corrupt stored data. An access that is already under way when reset asserts is given a short grace window. The window ends when the input chip-enable goes high or after a fixed number of time-base ticks, whichever comes first.

The block also reports backup-battery health to software without a status register. During the reset timeout stretch it samples a battery-low flag and holds the last sample. After reset releases, it counts chip-enable pulses. When the held flag reads low, it blocks the second pulse only. Firmware can write a pattern and read it back to find out whether that write reached memory.

All gating is combinational from the chip-enable input to the output. Registered state only decides whether the path is open.

Top module: `cegate_battchk`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it rises while `rst_act` is still high, `ce_out_n` is 1 whatever the value of `ce_in_n`.
- R2: With `rst_act` low and no suppression in force, `ce_out_n` equals `ce_in_n` in the same cycle, and `ce_out_n` is never 0 while `ce_in_n` is 1.
- R3: With `rst_act` high and no grace window open, `ce_out_n` is 1 regardless of `ce_in_n`. This covers both the power-up stretch and a manual reset.
- R4: If `ce_in_n` is 0 in the first cycle in which `rst_act` is 1 (it was 0 in the cycle before), `ce_out_n` keeps following `ce_in_n` low. Once `ce_in_n` returns to 1, the output stays 1 until `rst_act` falls, even if `ce_in_n` goes low again.
- R5: A grace window that `ce_in_n` does not end closes at the clock edge of the GRACE_TICKS-th `tick` strobe counted after its opening cycle. From then on `ce_out_n` is 1.
- R6: If `ce_in_n` is 1 when `rst_act` rises, no grace window opens, and a later low on `ce_in_n` during reset is blocked.
- R7: The battery result is the value of `batt_low` in the last cycle of a run of cycles with `tmo_act` high. Changes of `batt_low` while `tmo_act` is low have no effect on which pulse passes.
- R8: With the held result low (1), the second falling edge of `ce_in_n` after `rst_act` falls is blocked. `ce_out_n` stays 1 for that whole low period of `ce_in_n`.
- R9: The first pulse, and the third and all later pulses, pass unchanged. With the held result good (0), every pulse passes. The pulse count saturates at 3.
- R10: Each new period of `rst_act` high restarts the pulse count, so the second pulse after every reset release is judged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the gate state |
| tick | input | 1 | One-cycle time-base strobe for the grace window |
| ce_in_n | input | 1 | Active-low chip-enable from the processor |
| rst_act | input | 1 | Supervisor reset active, including the timeout stretch |
| tmo_act | input | 1 | Reset timeout stretch in progress; battery sampling window |
| batt_low | input | 1 | Backup battery below its threshold (1 = low) |
| ce_out_n | output | 1 | Active-low chip-enable to the memory |

## Verification
Directed sequences tell apart a reset that arrives during an access from one that arrives between accesses. They also separate a grace window closed by the input from one closed by the tick count, and a window closed one tick early from one closed one tick late. Pulse trains of four and more after release, run with the battery result good and low and across two reset sequences, separate suppression of the second pulse from suppression of a neighbour or a missed count restart. Toggling `batt_low` outside the sampling window, and changing it inside the window, show which sample is kept. A constrained random stream of reset episodes, access pulses and ticks is then compared cycle by cycle with a bench model.

// File: rtl/cegate_pkg.sv
package cegate_pkg;
  typedef logic [1:0] pulse_cnt_t;

  localparam pulse_cnt_t PULSE_SAT    = 2'd3;
  localparam pulse_cnt_t PULSE_BEFORE = 2'd1;

  function automatic pulse_cnt_t pulse_next(input pulse_cnt_t c);
    return (c == PULSE_SAT) ? c : pulse_cnt_t'(c + 2'd1);
  endfunction

  function automatic logic is_blocked_pulse(input pulse_cnt_t c, input logic low);
    return low && (c == PULSE_BEFORE);
  endfunction
endpackage

// File: rtl/cegate_grace.sv
module cegate_grace #(
  parameter int GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ce_in_n,
  input  logic rst_act,
  input  logic rst_rise,
  output logic grace_act
);
  localparam int GW = $clog2(GRACE_TICKS + 1);
  localparam logic [GW-1:0] LAST = GW'(GRACE_TICKS - 1);

  logic          grace_on;
  logic [GW-1:0] gcnt;
  logic          grace_start;

  function automatic logic grace_expires(input logic [GW-1:0] c, input logic t);
    return t && (c == LAST);
  endfunction

  assign grace_start = rst_rise && !ce_in_n;
  assign grace_act   = grace_start || grace_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_on <= 1'b0;
      gcnt     <= '0;
    end else if (!rst_act || ce_in_n) begin
      grace_on <= 1'b0;
      gcnt     <= '0;
    end else if (grace_start) begin
      grace_on <= 1'b1;
      gcnt     <= '0;
    end else if (grace_on && tick) begin
      if (grace_expires(gcnt, tick)) grace_on <= 1'b0;
      gcnt <= gcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cegate_batt.sv
module cegate_batt
  import cegate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_act,
  input  logic       tmo_act,
  input  logic       batt_low,
  input  logic       ce_in_n,
  input  logic       ce_fall,
  output logic       sup_act,
  output logic       low_lat,
  output pulse_cnt_t pulse_cnt
);
  logic sup_hold;
  logic sup_now;

  assign sup_now = !rst_act && ce_fall && is_blocked_pulse(pulse_cnt, low_lat);
  assign sup_act = sup_now || sup_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_lat <= 1'b0;
    else if (tmo_act) low_lat <= batt_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pulse_cnt <= '0;
    else if (rst_act) pulse_cnt <= '0;
    else if (ce_fall) pulse_cnt <= pulse_next(pulse_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sup_hold <= 1'b0;
    else if (rst_act || ce_in_n) sup_hold <= 1'b0;
    else if (sup_now)            sup_hold <= 1'b1;
  end
endmodule

// File: rtl/cegate_battchk.sv
module cegate_battchk
  import cegate_pkg::*;
#(
  parameter int GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ce_in_n,
  input  logic rst_act,
  input  logic tmo_act,
  input  logic batt_low,
  output logic ce_out_n
);
  logic       rst_q;
  logic       ce_q;
  logic       rst_rise;
  logic       ce_fall;
  logic       grace_act;
  logic       sup_act;
  logic       low_lat;
  pulse_cnt_t pulse_cnt;
  logic       pass_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      ce_q  <= 1'b1;
    end else begin
      rst_q <= rst_act;
      ce_q  <= ce_in_n;
    end
  end

  assign rst_rise = rst_act && !rst_q;
  assign ce_fall  = !ce_in_n && ce_q;

  cegate_grace #(.GRACE_TICKS(GRACE_TICKS)) u_grace (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ce_in_n   (ce_in_n),
    .rst_act   (rst_act),
    .rst_rise  (rst_rise),
    .grace_act (grace_act)
  );

  cegate_batt u_batt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_act   (rst_act),
    .tmo_act   (tmo_act),
    .batt_low  (batt_low),
    .ce_in_n   (ce_in_n),
    .ce_fall   (ce_fall),
    .sup_act   (sup_act),
    .low_lat   (low_lat),
    .pulse_cnt (pulse_cnt)
  );

  assign pass_en  = rst_n && ((!rst_act && !sup_act) || grace_act);
  assign ce_out_n = !(pass_en && !ce_in_n);
endmodule

// File: rtl/cegate_battchk_chk.sv
module cegate_battchk_chk #(
  parameter int GRACE_TICKS = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ce_in_n,
  input logic       rst_act,
  input logic       tmo_act,
  input logic       ce_out_n,
  input logic       grace_act,
  input logic       sup_act,
  input logic       ce_fall,
  input logic       low_lat,
  input logic [1:0] pulse_cnt
);
  localparam int CW = $clog2(GRACE_TICKS + 2);
  logic [CW-1:0] win_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_ticks <= '0;
    else if (!grace_act) win_ticks <= '0;
    else if (tick)       win_ticks <= win_ticks + 1'b1;
  end

  always_comb begin
    if (!rst_n) AST_INIT_HIGH: assert (ce_out_n); // R1
  end

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_out_n |-> !ce_in_n); // R2

  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && !sup_act) |-> (ce_out_n == ce_in_n)); // R2

  AST_BLOCK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && !grace_act) |-> ce_out_n); // R3

  AST_NO_LATE_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && $past(rst_act) && $past(ce_in_n)) |-> ce_out_n); // R4

  AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    grace_act |-> (win_ticks <= CW'(GRACE_TICKS))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_act |=> $stable(low_lat)); // R7

  AST_SECOND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && ce_fall && pulse_cnt == 2'd1 && low_lat) |-> ce_out_n); // R8

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt == 2'd3 && !rst_act) |=> (pulse_cnt == 2'd3)); // R9

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (pulse_cnt == 2'd0)); // R10
endmodule

bind cegate_battchk cegate_battchk_chk #(.GRACE_TICKS(GRACE_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .ce_in_n   (ce_in_n),
  .rst_act   (rst_act),
  .tmo_act   (tmo_act),
  .ce_out_n  (ce_out_n),
  .grace_act (grace_act),
  .sup_act   (sup_act),
  .ce_fall   (ce_fall),
  .low_lat   (low_lat),
  .pulse_cnt (pulse_cnt)
);

// File: tb/test_cegate_battchk.sv
module test_cegate_battchk;
  localparam int G = 15;

  logic clk = 1'b0;
  logic rst_n, tick, ce_in_n, rst_act, tmo_act, batt_low;
  logic ce_out_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model state
  bit m_rq, m_cq, m_gon, m_low, m_hold;
  int m_g, m_cnt;

  always #4 clk = ~clk;

  cegate_battchk #(.GRACE_TICKS(G)) i_cegate_battchk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ce_in_n(ce_in_n),
    .rst_act(rst_act), .tmo_act(tmo_act), .batt_low(batt_low),
    .ce_out_n(ce_out_n)
  );

  function automatic bit exp_out();
    bit open_now, in_grace, falling, blocked, allowed;
    open_now = rst_act && !m_rq && !ce_in_n;
    in_grace = open_now || m_gon;
    falling  = !ce_in_n && m_cq;
    blocked  = m_hold || (!rst_act && falling && m_cnt == 1 && m_low);
    allowed  = in_grace || (!rst_act && !blocked);
    if (!rst_n) return 1'b1;
    return ce_in_n ? 1'b1 : !allowed;
  endfunction

  task automatic model_step();
    bit falling;
    falling = !ce_in_n && m_cq;
    if (!rst_act || ce_in_n) begin m_gon = 0; m_g = 0; end
    else if (!m_rq) begin m_gon = 1; m_g = 0; end
    else if (m_gon && tick) begin
      if (m_g == G - 1) m_gon = 0;
      m_g++;
    end
    if (rst_act || ce_in_n) m_hold = 0;
    else if (falling && m_cnt == 1 && m_low) m_hold = 1;
    if (rst_act) m_cnt = 0;
    else if (falling && m_cnt < 3) m_cnt++;
    if (tmo_act) m_low = batt_low;
    m_rq = rst_act;
    m_cq = ce_in_n;
  endtask

  task automatic check(input string tag);
    bit e;
    e = exp_out();
    total++;
    if (ce_out_n !== e) begin
      bad++;
      $display("FAIL %s: ce_out_n=%b expected %b at %0t", tag, ce_out_n, e, $time);
    end
  endtask

  task automatic cyc(input bit r, input bit t, input bit c, input bit b, input bit k,
                     input string tag);
    rst_act = r; tmo_act = t; ce_in_n = c; batt_low = b; tick = k;
    #1;
    check(tag);
    @(posedge clk);
    if (rst_n) model_step();
    #2;
  endtask

  // full reset sequence: hold, then timeout window sampling battery
  task automatic reset_seq(input bit last_batt, input string tag);
    cyc(0, 0, 1, 0, 0, tag);
    for (int i = 0; i < 3; i++) cyc(1, 0, i[0], 0, 0, tag);
    for (int i = 0; i < 4; i++) cyc(1, 1, i[0], !last_batt, 0, tag);
    cyc(1, 1, 1, last_batt, 0, tag);
    cyc(0, 0, 1, !last_batt, 0, tag);
  endtask

  task automatic pulse(input int len, input string tag);
    for (int i = 0; i < len; i++) cyc(0, 0, 0, 0, 0, tag);
    cyc(0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: ran out of cycles, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rst_act = 1; tmo_act = 0; ce_in_n = 0; batt_low = 0; tick = 0;
    m_rq = 1; m_cq = 1; m_gon = 0; m_low = 0; m_hold = 0; m_g = 0; m_cnt = 0;
    @(posedge clk); #2;
    cyc(1, 0, 0, 0, 0, "R1 init");
    cyc(1, 0, 0, 0, 0, "R1 init");
    rst_n = 1;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R1 after init");

    // good battery: all pulses pass; R7 window last sample good
    reset_seq(1'b0, "R3 R7 window");
    for (int p = 0; p < 4; p++) pulse(3, "R9 good battery");
    // toggling batt_low outside window ignored (R7)
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, i[0], 0, "R7 outside");
    pulse(2, "R7 first"); pulse(2, "R7 second passes");

    // low battery: only the second pulse blocked
    reset_seq(1'b1, "R3 R7 low window");
    pulse(3, "R9 first passes");
    pulse(5, "R8 second blocked");
    pulse(3, "R9 third passes");
    pulse(3, "R9 fourth passes");
    // second sequence: count restarts (R10)
    reset_seq(1'b1, "R10 window");
    pulse(2, "R10 first");
    pulse(4, "R10 second blocked again");
    pulse(2, "R10 third");

    // grace closed by input (R4)
    cyc(0, 0, 0, 0, 0, "R4 access");
    cyc(1, 0, 0, 0, 0, "R4 reset during access");
    cyc(1, 0, 0, 0, 1, "R4 grace");
    cyc(1, 0, 1, 0, 0, "R4 input ends");
    cyc(1, 0, 0, 0, 0, "R4 relow blocked");
    cyc(1, 0, 0, 0, 0, "R4 relow blocked");
    cyc(0, 0, 1, 0, 0, "R4 release");

    // grace closed by ticks (R5)
    cyc(0, 0, 0, 0, 0, "R5 access");
    cyc(1, 0, 0, 0, 0, "R5 open");
    for (int i = 0; i < G; i++) begin
      cyc(1, 0, 0, 0, 0, "R5 between ticks");
      cyc(1, 0, 0, 0, 1, "R5 tick");
    end
    cyc(1, 0, 0, 0, 0, "R5 expired");
    cyc(1, 0, 0, 0, 1, "R5 expired");
    cyc(0, 0, 1, 0, 0, "R5 release");

    // reset arrives between accesses (R6)
    cyc(0, 0, 1, 0, 0, "R6 idle");
    cyc(1, 0, 1, 0, 0, "R6 reset idle");
    cyc(1, 0, 0, 0, 0, "R6 blocked");
    cyc(1, 0, 0, 0, 1, "R6 blocked");
    cyc(0, 0, 1, 0, 0, "R6 release");

    // constrained random episodes
    void'($urandom(32'h5eed_c0de));
    for (int ep = 0; ep < 120; ep++) begin
      int rl, pl;
      rl = 2 + ($urandom % 12);
      for (int i = 0; i < rl; i++)
        cyc(1, (i >= rl / 2), $urandom % 3 != 0, $urandom % 2,
            $urandom % 3 == 0, "R3 R5 random reset");
      pl = 10 + ($urandom % 30);
      for (int i = 0; i < pl; i++)
        cyc(0, 0, $urandom % 2, $urandom % 2, $urandom % 2, "R2 R8 R9 random run");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule